// File: doc/BRIEF.md
# Control-Aware Lane Byte Scrambler

This block whitens the byte stream of one lane of an 8b/10b-coded serial link, one byte per clock. Each incoming byte carries a valid strobe and a flag that marks it as a control character or a data character. Data bytes leave XORed with eight bits taken from a 16-bit Galois linear-feedback shift register. Control bytes leave untouched. The result is registered, so it appears one clock after the input.

Two control codes get special handling. The comma code (BCh with the control flag set) puts the generator back at its seed for the byte that follows. The skip code (1Ch with the control flag set) is passed through and leaves the generator exactly where it was. XOR is its own inverse, and the advance rules look only at the control flag and the byte value, which are the same on both sides of the link. The same module therefore scrambles on the transmit side and descrambles on the receive side, and needs no direction setting.

Top module: `lane_scrambler`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it, out_valid, out_ctrl and out_data are all 0. The generator state is FFFFh, so the first data byte after reset uses the mask derived from FFFFh.
- R2: The mask for a data byte is produced by eight Galois shift steps. Each step outputs the state's bit 15, then shifts left by one and, if that bit was 1, XORs in 0039h (x^16+x^5+x^4+x^3+1). The first output bit goes to data bit 0. A valid data byte appears XORed with this mask on out_data one clock later, with out_ctrl low, and the state moves to the value after the eight steps.
- R3: A valid byte with in_ctrl high appears on out_data unchanged one clock later, with out_ctrl high.
- R4: A valid comma (in_ctrl high, data BCh) loads FFFFh into the generator, so the next data byte uses the seed mask.
- R5: A valid skip (in_ctrl high, data 1Ch) leaves the generator state unchanged.
- R6: Any other valid control byte advances the generator by eight steps, the same as a data byte.
- R7: When in_valid is low, out_valid is 0 one clock later, and out_data, out_ctrl and the generator state keep their values.
- R8: A logical idle data byte 00h is scrambled like other data, so its output equals the mask.
- R9: Feeding the output of one instance straight into a second instance returns the original valid bytes and control flags, two clocks after the first input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_ctrl | input | 1 | Input byte is a control character |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_ctrl | output | 1 | Output byte is a control character |
| out_data | output | 8 | Scrambled or passed-through byte |

## Verification
The bench uses the default parameters: an 8-bit byte, a 16-bit generator, seed FFFFh, and comma and skip codes BCh and 1Ch. It chains two instances back to back, a scrambler followed by a descrambler. With the 8-bit byte, every data value and every control value can be driven exhaustively. The sweeps cross the comma and skip codes with the generator in many states. Gaps in the valid strobe sit between reseeds and holds, and every byte that crosses both instances is checked for a bit-exact round trip.

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS  = 16'h0039,
  parameter logic [LFSR_W-1:0] SEED  = 16'hFFFF,
  parameter logic [DATA_W-1:0] COMMA = 8'hBC,
  parameter logic [DATA_W-1:0] SKIP  = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ctrl,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_ctrl,
  output logic [DATA_W-1:0] out_data
);

  logic [LFSR_W-1:0] lfsr_q, lfsr_adv, lfsr_nxt;
  logic [DATA_W-1:0] mask;

  always_comb begin
    logic [LFSR_W-1:0] s;
    s = lfsr_q;
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = s[LFSR_W-1];
      s = {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? TAPS : '0);
    end
    lfsr_adv = s;
  end

  wire is_comma = in_ctrl && (in_data == COMMA);
  wire is_skip  = in_ctrl && (in_data == SKIP);

  assign lfsr_nxt = is_comma ? SEED : (is_skip ? lfsr_q : lfsr_adv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q    <= SEED;
      out_valid <= 1'b0;
      out_ctrl  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lfsr_q   <= lfsr_nxt;
        out_ctrl <= in_ctrl;
        out_data <= in_ctrl ? in_data : (in_data ^ mask);
      end
    end
  end

endmodule

// File: rtl/lane_scrambler_chk.sv
module lane_scrambler_chk #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hFFFF,
  parameter logic [DATA_W-1:0] COMMA = 8'hBC,
  parameter logic [DATA_W-1:0] SKIP  = 8'h1C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ctrl,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ctrl,
  input logic [DATA_W-1:0] out_data,
  input logic [LFSR_W-1:0] lfsr_q
);

  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ctrl |=> out_ctrl && out_valid && out_data == $past(in_data)); // R3

  AST_COMMA_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ctrl && in_data == COMMA |=> lfsr_q == SEED); // R4

  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ctrl && in_data == SKIP |=> $stable(lfsr_q)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(lfsr_q) && $stable(out_data) && $stable(out_ctrl)); // R7

  AST_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ctrl |=> out_valid && !out_ctrl); // R2

endmodule

bind lane_scrambler lane_scrambler_chk #(
  .DATA_W(DATA_W), .LFSR_W(LFSR_W), .SEED(SEED), .COMMA(COMMA), .SKIP(SKIP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
  .in_data(in_data), .out_valid(out_valid), .out_ctrl(out_ctrl),
  .out_data(out_data), .lfsr_q(lfsr_q)
);

// File: tb/lane_scrambler_tb.sv
module lane_scrambler_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ctrl = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic tx_valid, tx_ctrl, rx_valid, rx_ctrl;
  logic [7:0] tx_data, rx_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_scrambler u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl), .in_data(in_data),
    .out_valid(tx_valid), .out_ctrl(tx_ctrl), .out_data(tx_data)
  );

  lane_scrambler u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_ctrl(tx_ctrl), .in_data(tx_data),
    .out_valid(rx_valid), .out_ctrl(rx_ctrl), .out_data(rx_data)
  );

  logic [15:0] m_state = 16'hFFFF;
  logic [7:0]  last_data = 8'h00;
  logic        last_ctrl = 1'b0;
  logic        prev_v = 1'b0, prev_k = 1'b0;
  logic [7:0]  prev_d = 8'h00;

  function automatic logic [7:0] mask_of(input logic [15:0] s);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) begin
      m[i] = s[15];
      s = {s[14:0], 1'b0} ^ (s[15] ? 16'h0039 : 16'h0000);
    end
    return m;
  endfunction

  function automatic logic [15:0] step8(input logic [15:0] s);
    for (int i = 0; i < 8; i++)
      s = {s[14:0], 1'b0} ^ (s[15] ? 16'h0039 : 16'h0000);
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic send(input logic v, input logic k, input logic [7:0] d, input string req);
    logic [7:0] exp_d;
    logic       exp_k;
    in_valid = v; in_ctrl = k; in_data = d;
    if (v) begin
      exp_k = k;
      exp_d = k ? d : (d ^ mask_of(m_state));
    end else begin
      exp_k = last_ctrl;
      exp_d = last_data;
    end
    @(negedge clk);
    chk({req, " out_valid"}, {31'd0, tx_valid}, {31'd0, v});
    chk({req, " out_ctrl"},  {31'd0, tx_ctrl},  {31'd0, exp_k});
    chk({req, " out_data"},  {24'd0, tx_data},  {24'd0, exp_d});
    // R9: round trip through the second instance
    chk("R9 rx_valid", {31'd0, rx_valid}, {31'd0, prev_v});
    if (prev_v) begin
      chk("R9 rx_ctrl", {31'd0, rx_ctrl}, {31'd0, prev_k});
      chk("R9 rx_data", {24'd0, rx_data}, {24'd0, prev_d});
    end
    prev_v = v; prev_k = k; prev_d = d;
    last_ctrl = exp_k; last_data = exp_d;
    if (v) begin
      if (k && d == 8'hBC)      m_state = 16'hFFFF;
      else if (k && d == 8'h1C) m_state = m_state;
      else                      m_state = step8(m_state);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 out_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 out_ctrl",  {31'd0, tx_ctrl},  32'd0);
    chk("R1 out_data",  {24'd0, tx_data},  32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after release", {31'd0, tx_valid}, 32'd0);
    // R8 / R1: idle byte straight after reset gives the seed mask
    send(1, 0, 8'h00, "R8 idle seed mask");
    send(1, 0, 8'h00, "R8 idle second");
    // R2: every data value
    for (int i = 0; i < 256; i++) send(1, 0, i[7:0], "R2 data sweep");
    // R4: comma passes and reseeds
    send(1, 1, 8'hBC, "R4 comma");
    send(1, 0, 8'h00, "R4 seed after comma");
    send(1, 0, 8'hA5, "R4 second after comma");
    // R5: skips hold the generator
    send(1, 1, 8'h1C, "R5 skip");
    send(1, 1, 8'h1C, "R5 skip");
    send(1, 1, 8'h1C, "R5 skip");
    send(1, 0, 8'h00, "R5 data after skips");
    // R3 / R6: every control value, interleaved with data
    for (int i = 0; i < 256; i++) begin
      send(1, 1, i[7:0], "R3 R6 ctrl sweep");
      send(1, 0, 8'h3C ^ i[7:0], "R6 data after ctrl");
    end
    // R7: gaps hold state and output
    send(1, 0, 8'h5A, "R7 before gap");
    for (int i = 0; i < 4; i++) send(0, 0, 8'hFF, "R7 gap");
    send(1, 0, 8'h5A, "R7 after gap");
    send(1, 1, 8'hBC, "R7 comma before gap");
    send(0, 1, 8'h1C, "R7 gap after comma");
    send(1, 0, 8'h00, "R7 R4 seed after gap");
    send(1, 1, 8'h1C, "R7 skip before gap");
    send(0, 0, 8'h00, "R7 gap after skip");
    for (int i = 0; i < 64; i++) send(1, (i % 7) == 3, i[7:0] * 8'd37, "R2 mixed");
    send(0, 0, 8'h00, "R9 drain");
    send(0, 0, 8'h00, "R9 drain");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule